// File: doc/BRIEF.md
# CAN Interrupt Source Identifier

This block merges every interrupt source of a CAN controller into one request line and publishes a numeric code naming the most urgent pending source. Its sources are status changes (transmit success, receive success, a last-error-code update), changes of the error warning and bus-off flags, and per-object transmit and receive success strobes for 15 message objects. Object 15 is the last object and is used as a receive buffer. Each object keeps a sticky pending bit. That bit is set only when a transfer happens in a direction that the object has enabled.

Software reaches the block through a small register port. A control register holds the global request gate and the enables for the status class and the error class. A status register shows the controller flags, and reading it acknowledges the pending status/error source. A code register returns the current identification code. Each message object has its own register for its enables and its pending bit. An interrupt handler reads the code, services that source, and repeats until the code reads 0.

Top module: `can_irq_ident`

## Requirements
- R1: After synchronous reset, irq and irq_code are 0, and the control, status and object registers all read 0.
- R2: When no source is pending, irq_code is 0 and irq is low.
- R3: With the status enable (control bit 1) set, a transmit-OK strobe, a receive-OK strobe or a last-error-code update makes the status/error source pending, and irq_code becomes 1. With the status enable clear, the flags still update in the status register but no code results. Status register layout: bit0 transmit-OK, bit1 receive-OK, bits 4:2 last error code, bit5 warning, bit6 bus-off.
- R4: With the error enable (control bit 2) set, every change of the warning input or the bus-off input, rising or falling, makes the status/error source pending (code 1).
- R5: Object 15 sets its pending bit on a receive strobe while its receive enable is set, and that gives code 2. Transmit strobes on object 15 never set it.
- R6: Object n (1 to 14) sets its pending bit on a transmit strobe with its transmit enable set, or on a receive strobe with its receive enable set, and that gives code n+2. A strobe in a direction that is not enabled has no effect. Object register layout: bit0 transmit enable, bit1 receive enable, bit2 pending.
- R7: The lowest code among the pending sources is reported. A status/error source and an object source can be pending together after a single transfer.
- R8: Reading the status register (address 1) clears the pending status/error source. The code then moves to the next pending source.
- R9: An object pending bit stays set until software writes 0 to bit2 of that object's register. Writing 1 to bit2 leaves the bit unchanged.
- R10: Writing 0 to bit0 or bit1 of the status register clears transmit-OK or receive-OK. Writing 1 leaves the flag unchanged.
- R11: irq is registered. In the cycle after a clock edge at which the global enable (control bit 0) was set and the code was nonzero, irq is high. Otherwise irq is low. Addresses: control 0, status 1, code 2, object n at 16+n. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_txok | input | 1 | Transmit success strobe |
| ev_rxok | input | 1 | Receive success strobe |
| ev_lec_upd | input | 1 | Last error code update strobe |
| ev_lec | input | 3 | New last error code value |
| warn_in | input | 1 | Error warning level flag |
| busoff_in | input | 1 | Bus-off level flag |
| obj_tx_ok | input | 15 | Per-object transmit success strobes, bit i = object i+1 |
| obj_rx_ok | input | 15 | Per-object receive success strobes, bit i = object i+1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after reg_rd |
| irq_code | output | 5 | Current identification code |
| irq | output | 1 | Registered interrupt request |

## Verification
A table of single-object events walks through objects at both ends of the range and in the middle, in both directions, with the matching enable set and with it clear. This separates the offset of the code mapping, the direction gating and the special handling of object 15. Directed sequences then fire several sources in the same cycle, which shows whether the encoder picks the lowest code and whether a status read hands over to the object that was waiting. Separate flag-write patterns of 0 and 1, rising and falling error flags, and a toggled global gate each isolate the clear-on-zero rule, the change detection and the registered request.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int NOBJ   = 15;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int CODE_W = $clog2(NOBJ + 3);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(2);
    localparam int OBJ_BASE = 16;

    // control bits
    localparam int C_IE  = 0;
    localparam int C_SIE = 1;
    localparam int C_EIE = 2;

    // object register bits
    localparam int O_TXIE = 0;
    localparam int O_RXIE = 1;
    localparam int O_PND  = 2;

    typedef struct packed {
        logic       busoff;
        logic       warn;
        logic [2:0] lec;
        logic       rxok;
        logic       txok;
    } stat_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_OBJ  = 2'd3
    } sel_e;

    // lowest code among pending sources; 0 when idle
    function automatic logic [CODE_W-1:0] pick_code(
        input logic            se,
        input logic [NOBJ-1:0] pend
    );
        logic [CODE_W-1:0] c;
        c = '0;
        if (se) begin
            c = CODE_W'(1);
        end else if (pend[NOBJ-1]) begin
            c = CODE_W'(2);
        end else begin
            for (int i = NOBJ - 2; i >= 0; i--) begin
                if (pend[i]) c = CODE_W'(i + 3);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/can_irq_status.sv
module can_irq_status
    import can_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_txok,
    input  logic        ev_rxok,
    input  logic        ev_lec_upd,
    input  logic [2:0]  ev_lec,
    input  logic        warn_in,
    input  logic        busoff_in,
    input  logic        sie,
    input  logic        eie,
    input  logic        wr_stat,
    input  logic [1:0]  wr_keep,
    input  logic        rd_stat,
    output stat_t       stat,
    output logic        se_pend
);

    stat_t stat_q;
    logic  pend_q;
    logic  st_evt, er_evt, set_pend;

    assign st_evt   = ev_txok | ev_rxok | ev_lec_upd;
    assign er_evt   = (warn_in != stat_q.warn) | (busoff_in != stat_q.busoff);
    assign set_pend = (sie & st_evt) | (eie & er_evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            pend_q <= 1'b0;
        end else begin
            stat_q.warn   <= warn_in;
            stat_q.busoff <= busoff_in;
            if (ev_lec_upd) stat_q.lec <= ev_lec;
            if (ev_txok)
                stat_q.txok <= 1'b1;
            else if (wr_stat && !wr_keep[0])
                stat_q.txok <= 1'b0;
            if (ev_rxok)
                stat_q.rxok <= 1'b1;
            else if (wr_stat && !wr_keep[1])
                stat_q.rxok <= 1'b0;
            if (set_pend)
                pend_q <= 1'b1;
            else if (rd_stat)
                pend_q <= 1'b0;
        end
    end

    assign stat    = stat_q;
    assign se_pend = pend_q;

    // R8: status read without a new event acknowledges the source
    p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !set_pend) |=> !se_pend);

    // R3: enabled transmit success raises pending and the flag
    p_txok_set_r3: assert property (@(posedge clk) disable iff (rst)
        (sie && ev_txok) |=> (se_pend && stat.txok));

    // R4: enabled warning change raises pending
    p_warn_chg_r4: assert property (@(posedge clk) disable iff (rst)
        (eie && (warn_in != stat.warn)) |=> se_pend);

endmodule

// File: rtl/can_irq_objects.sv
module can_irq_objects
    import can_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NOBJ-1:0] ev_tx,
    input  logic [NOBJ-1:0] ev_rx,
    input  logic [NOBJ-1:0] wr_obj,
    input  logic [2:0]      wdata,
    output logic [NOBJ-1:0] txie,
    output logic [NOBJ-1:0] rxie,
    output logic [NOBJ-1:0] pend
);

    for (genvar g = 0; g < NOBJ; g++) begin : g_obj
        logic tie_q, rie_q, pnd_q, hit;
        logic clr;

        if (g == NOBJ - 1) begin : g_last
            // receive buffer object: transmit direction plays no part
            assign hit = ev_rx[g] & rie_q;
        end else begin : g_norm
            assign hit = (ev_tx[g] & tie_q) | (ev_rx[g] & rie_q);
        end

        assign clr = wr_obj[g] & ~wdata[O_PND];

        always_ff @(posedge clk) begin
            if (rst) begin
                tie_q <= 1'b0;
                rie_q <= 1'b0;
                pnd_q <= 1'b0;
            end else begin
                if (wr_obj[g]) begin
                    tie_q <= wdata[O_TXIE];
                    rie_q <= wdata[O_RXIE];
                end
                if (hit)
                    pnd_q <= 1'b1;
                else if (clr)
                    pnd_q <= 1'b0;
            end
        end

        assign txie[g] = tie_q;
        assign rxie[g] = rie_q;
        assign pend[g] = pnd_q;

        // R9: pending holds until a zero is written to it
        p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (pend[g] && !clr) |=> pend[g]);

        // R6: enabled receive sets pending
        p_rx_set_r6: assert property (@(posedge clk) disable iff (rst)
            (ev_rx[g] && rxie[g]) |=> pend[g]);
    end

    // R5: transmit on the last object alone never sets it
    p_last_tx_r5: assert property (@(posedge clk) disable iff (rst)
        (!pend[NOBJ-1] && !ev_rx[NOBJ-1]) |=> !pend[NOBJ-1]);

endmodule

// File: rtl/can_irq_encoder.sv
module can_irq_encoder
    import can_irq_pkg::*;
(
    input  logic              se_pend,
    input  logic [NOBJ-1:0]   obj_pend,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        code = pick_code(se_pend, obj_pend);
    end

endmodule

// File: rtl/can_irq_ident.sv
module can_irq_ident
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_txok,
    input  logic              ev_rxok,
    input  logic              ev_lec_upd,
    input  logic [2:0]        ev_lec,
    input  logic              warn_in,
    input  logic              busoff_in,
    input  logic [NOBJ-1:0]   obj_tx_ok,
    input  logic [NOBJ-1:0]   obj_rx_ok,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CODE_W-1:0] irq_code,
    output logic              irq
);

    localparam int OBJ_IDX_W = $clog2(NOBJ + 1);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;
    stat_t             stat;
    logic              se_pend;
    logic [NOBJ-1:0]   obj_pend, obj_txie, obj_rxie, wr_obj;
    logic [CODE_W-1:0] code;
    sel_e              sel;
    logic [OBJ_IDX_W-1:0] obj_idx;
    logic              obj_ok;

    // address decode
    assign obj_idx = OBJ_IDX_W'(reg_addr - ADDR_W'(OBJ_BASE + 1));
    assign obj_ok  = (reg_addr >= ADDR_W'(OBJ_BASE + 1)) &&
                     (reg_addr <= ADDR_W'(OBJ_BASE + NOBJ));

    always_comb begin
        if (reg_addr == A_CTRL)      sel = SEL_CTRL;
        else if (reg_addr == A_STAT) sel = SEL_STAT;
        else if (obj_ok)             sel = SEL_OBJ;
        else                         sel = SEL_NONE;
    end

    for (genvar g = 0; g < NOBJ; g++) begin : g_wsel
        assign wr_obj[g] = reg_wr && (sel == SEL_OBJ) && (obj_idx == OBJ_IDX_W'(g));
    end

    can_irq_status u_status (
        .clk        (clk),
        .rst        (rst),
        .ev_txok    (ev_txok),
        .ev_rxok    (ev_rxok),
        .ev_lec_upd (ev_lec_upd),
        .ev_lec     (ev_lec),
        .warn_in    (warn_in),
        .busoff_in  (busoff_in),
        .sie        (ctrl_q[C_SIE]),
        .eie        (ctrl_q[C_EIE]),
        .wr_stat    (reg_wr && (sel == SEL_STAT)),
        .wr_keep    (reg_wdata[1:0]),
        .rd_stat    (reg_rd && (sel == SEL_STAT)),
        .stat       (stat),
        .se_pend    (se_pend)
    );

    can_irq_objects u_objects (
        .clk    (clk),
        .rst    (rst),
        .ev_tx  (obj_tx_ok),
        .ev_rx  (obj_rx_ok),
        .wr_obj (wr_obj),
        .wdata  (reg_wdata[2:0]),
        .txie   (obj_txie),
        .rxie   (obj_rxie),
        .pend   (obj_pend)
    );

    can_irq_encoder u_encoder (
        .se_pend  (se_pend),
        .obj_pend (obj_pend),
        .code     (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= ctrl_q[C_IE] && (code != '0);
            if (reg_wr && sel == SEL_CTRL) ctrl_q <= reg_wdata;
            if (reg_rd) begin
                if (reg_addr == A_CODE)
                    rdata_q <= DATA_W'(code);
                else begin
                    case (sel)
                        SEL_CTRL: rdata_q <= ctrl_q;
                        SEL_STAT: rdata_q <= DATA_W'(stat);
                        SEL_OBJ:  rdata_q <= DATA_W'({obj_pend[obj_idx],
                                                      obj_rxie[obj_idx],
                                                      obj_txie[obj_idx]});
                        default:  rdata_q <= '0;
                    endcase
                end
            end
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_code  = code;
    assign irq       = irq_q;

    // R11: request follows gate and code one edge later
    p_irq_on_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[C_IE] && irq_code != '0) |=> irq);
    p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[C_IE] || irq_code == '0) |=> !irq);

    // R7: an object code implies no higher-priority source pending
    p_prio_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_code >= CODE_W'(3)) |-> (!se_pend && !obj_pend[NOBJ-1]));

    // R2: code 0 only when nothing is pending
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_code == '0) |-> (!se_pend && obj_pend == '0));

endmodule

// File: tb/can_irq_ident_tb.sv
module can_irq_ident_tb;
    import can_irq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_txok = 0, ev_rxok = 0, ev_lec_upd = 0;
    logic [2:0] ev_lec = '0;
    logic warn_in = 0, busoff_in = 0;
    logic [NOBJ-1:0] obj_tx_ok = '0, obj_rx_ok = '0;
    logic reg_wr = 0, reg_rd = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [CODE_W-1:0] irq_code;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] rv;

    always #4 clk = ~clk;

    can_irq_ident u_dut (.*);

    typedef struct packed {
        logic [4:0] obj;
        logic       rx;
        logic       en;
        logic [4:0] code;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  1'b0, 1'b1, 5'd3},
        '{5'd1,  1'b1, 1'b1, 5'd3},
        '{5'd7,  1'b1, 1'b1, 5'd9},
        '{5'd14, 1'b0, 1'b1, 5'd16},
        '{5'd14, 1'b1, 1'b0, 5'd0},
        '{5'd15, 1'b1, 1'b1, 5'd2},
        '{5'd15, 1'b0, 1'b1, 5'd0},
        '{5'd3,  1'b0, 1'b0, 5'd0},
        '{5'd10, 1'b1, 1'b1, 5'd12},
        '{5'd2,  1'b0, 1'b1, 5'd4}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        reg_rd = 1; reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic pulse_obj(input int obj, input logic rx);
        if (rx) obj_rx_ok[obj-1] = 1'b1; else obj_tx_ok[obj-1] = 1'b1;
        @(negedge clk);
        obj_rx_ok = '0; obj_tx_ok = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 code", irq_code, 0);
        chk("R1 irq", irq, 0);
        rd(0, rv); chk("R1 ctrl", rv, 0);
        rd(1, rv); chk("R1 stat", rv, 0);
        rd(31, rv); chk("R1 obj15", rv, 0);

        // vector table: single object events (R5, R6, R2)
        foreach (VECS[i]) begin
            wr(OBJ_BASE + VECS[i].obj,
               (VECS[i].en && VECS[i].rx) ? 2 : (VECS[i].en ? 1 : 0));
            pulse_obj(VECS[i].obj, VECS[i].rx);
            chk(VECS[i].obj == 15 ? "R5 obj15" : "R6 obj code", irq_code, VECS[i].code);
            wr(OBJ_BASE + VECS[i].obj, 0);
            chk("R2 idle after clear", irq_code, 0);
        end

        // R3 status disabled: flag set but no code
        ev_txok = 1; @(negedge clk); ev_txok = 0;
        chk("R3 no code w/o enable", irq_code, 0);
        rd(1, rv); chk("R3 txok flag", rv, 1);
        // R3 enabled
        wr(0, 2);
        ev_rxok = 1; @(negedge clk); ev_rxok = 0;
        chk("R3 rxok code", irq_code, 1);
        rd(1, rv); chk("R8 stat read data", rv, 3);
        chk("R8 cleared by read", irq_code, 0);
        // R10 write 0 clears txok, 1 keeps rxok
        wr(1, 2);
        rd(1, rv); chk("R10 clear-on-zero", rv, 2);
        wr(1, 3);
        rd(1, rv); chk("R10 write one keeps", rv, 2);
        wr(1, 0);
        // R3 last error code
        ev_lec_upd = 1; ev_lec = 3'd5; @(negedge clk); ev_lec_upd = 0;
        chk("R3 lec code", irq_code, 1);
        rd(1, rv); chk("R3 lec field", rv, 5 << 2);

        // R4 error changes
        wr(0, 4);
        warn_in = 1; @(negedge clk);
        chk("R4 warn rise", irq_code, 1);
        rd(1, rv); chk("R4 warn bit", rv[5], 1);
        chk("R4 cleared", irq_code, 0);
        warn_in = 0; @(negedge clk);
        chk("R4 warn fall", irq_code, 1);
        rd(1, rv);
        busoff_in = 1; @(negedge clk);
        chk("R4 busoff rise", irq_code, 1);
        rd(1, rv); chk("R4 busoff bit", rv[6], 1);
        wr(0, 0);
        busoff_in = 0; @(negedge clk);
        chk("R4 no code w/o enable", irq_code, 0);

        // R7 status + object in same cycle
        wr(0, 2);
        wr(OBJ_BASE + 5, 1);
        ev_txok = 1; obj_tx_ok[4] = 1; @(negedge clk);
        ev_txok = 0; obj_tx_ok = '0;
        chk("R7 status first", irq_code, 1);
        rd(1, rv);
        chk("R8 hands over to object", irq_code, 7);
        // R9 pending persists
        wr(OBJ_BASE + 5, 5);
        chk("R9 write one keeps", irq_code, 7);
        rd(OBJ_BASE + 5, rv); chk("R9 obj reg", rv, 5);
        // R7 object 15 beats object 2, object 2 beats 9
        wr(OBJ_BASE + 15, 2); wr(OBJ_BASE + 2, 2); wr(OBJ_BASE + 9, 1);
        obj_rx_ok[14] = 1; obj_rx_ok[1] = 1; obj_tx_ok[8] = 1; @(negedge clk);
        obj_rx_ok = '0; obj_tx_ok = '0;
        chk("R7 obj15 highest object", irq_code, 2);
        wr(OBJ_BASE + 15, 0);
        chk("R7 obj2 next", irq_code, 4);
        wr(OBJ_BASE + 2, 0);
        chk("R7 obj5 next", irq_code, 7);
        wr(OBJ_BASE + 5, 0);
        chk("R7 obj9 next", irq_code, 11);
        rd(2, rv); chk("R7 code register", rv, 11);

        // R11 registered request with gate
        chk("R11 gate off", irq, 0);
        wr(0, 1);
        chk("R11 one cycle after gate", irq, 0);
        @(negedge clk);
        chk("R11 irq high", irq, 1);
        wr(OBJ_BASE + 9, 0);
        chk("R11 still high one cycle", irq, 1);
        @(negedge clk);
        chk("R11 drops when idle", irq, 0);
        wr(OBJ_BASE + 3, 2);
        pulse_obj(3, 1'b1);
        chk("R11 irq lags code", irq, 0);
        @(negedge clk);
        chk("R11 irq follows", irq, 1);
        wr(0, 0);
        @(negedge clk);
        chk("R11 masked", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule